// File: doc/BRIEF.md
# ATA Multiword DMA Host Engine

This block is the host side of an ATA multiword DMA burst for timing modes 0, 1 and 2. Once the engine is started with a direction, a mode and a word count, it waits for the device to raise its DMA request. It then asserts the DMA acknowledge and issues a train of read or write strobe pulses. Each pulse moves one 16-bit word between the drive data bus and a valid/ready word stream that faces a buffer.

All bus timing is derived at elaboration from nanosecond minimums and the clock period parameter `CLK_NS`. Each interval is rounded up to whole cycles, so no minimum is ever shortened. The request line from the device may fall late after a strobe. For that reason the engine samples it only at the end of each negated interval, which is sized to cover the worst-case drop delay.

A burst ends when the programmed count is used up or when the request is found low at that sample point. The acknowledge is then held for the mode's hold margin and released. A one-cycle done pulse reports how many words moved. A stalled stream (read side full, write side empty) stretches the negated time before the next strobe.

Top module: `mdma_host`

## Requirements
- R1: After reset, dmack_o, dior_o, diow_o, dd_oe_o, busy_o, done_o, rd_valid_o and wr_ready_o are all low.
- R2: A start with count 0 produces a done pulse with done_count_o = 0 and never asserts dmack_o.
- R3: dmack_o is not asserted while dmarq_i is low after a start, and no strobe is issued while dmack_o is low.
- R4: Each strobe (dior_o or diow_o, active high, never both) stays active for exactly ceil(240/80/80 ns / CLK_NS) cycles in modes 0/1/2.
- R5: Between two strobes of one burst, the strobe lines stay negated for at least ceil(max(negated minimum, cycle time − active width, request drop delay) / CLK_NS) cycles. The negated minimum is 80/80/40 ns for reads and 240/80/40 ns for writes. The cycle time is 480/160/120 ns. The request drop delay is 120/40/35 ns for reads and 40/40/35 ns for writes.
- R6: On a read (dir_i = 0), word n of the burst is the value of dd_i at the end of strobe n, and it is delivered on rd_data_o in order.
- R7: On a write (dir_i = 1), word n accepted from the wr stream is driven on dd_o with dd_oe_o high. It is stable for at least ceil(100/30/20 ns / CLK_NS) cycles before diow_o rises and throughout the strobe.
- R8: With dmarq_i held high, the burst moves exactly count_i words and done_count_o equals count_i.
- R9: dmarq_i is sampled at the end of each negated interval. If it is low there, the burst ends and done_count_o equals the words already moved.
- R10: After the last strobe negates, dmack_o stays high for at least ceil(20/5/5 ns / CLK_NS) cycles before it falls.
- R11: When the read stream is not ready or the write stream has no valid word, the next strobe is delayed and no word is lost, duplicated or reordered.
- R12: A mode_i value of 3 uses the mode 0 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a burst when idle |
| dir_i | input | 1 | 0 = read from device, 1 = write to device |
| mode_i | input | 2 | Multiword DMA timing mode 0..2 (3 acts as 0) |
| count_i | input | CNT_W | Words to transfer |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| done_count_o | output | CNT_W | Words moved, valid with done_o |
| dmarq_i | input | 1 | Device DMA request |
| dmack_o | output | 1 | DMA acknowledge, active high |
| dior_o | output | 1 | Read strobe, active high |
| diow_o | output | 1 | Write strobe, active high |
| dd_i | input | DW | Drive data bus input |
| dd_o | output | DW | Drive data bus output |
| dd_oe_o | output | 1 | Output enable for dd_o |
| rd_data_o | output | DW | Read stream word |
| rd_valid_o | output | 1 | Read stream valid |
| rd_ready_i | input | 1 | Read stream ready |
| wr_data_i | input | DW | Write stream word |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |

## Verification
A wrong sequencer state or timer value shows up at the strobe pins within one word period. The symptom is a pulse width that differs from the expected cycle count, or a negated gap shorter than the mode's minimum, and both are measured edge to edge for every word. A wrong remaining-word count, or a late or early request sample, appears at the end of the burst as a done count that disagrees with the programmed count or with the word after which the request dropped. A lost or overwritten data word shows as an out-of-order or wrong value on the stream or the bus, at the word where it happened.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam int NMODES = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PREP, ST_SETUP, ST_STROBE, ST_GAP, ST_HOLD, ST_FIN
  } mdma_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cyc_ns(input int m);
    case (m) 0: return 480; 1: return 160; default: return 120; endcase
  endfunction

  function automatic int act_ns(input int m);
    case (m) 0: return 240; default: return 80; endcase
  endfunction

  function automatic int neg_ns(input int m, input bit wr);
    case (m) 0: return wr ? 240 : 80; 1: return 80; default: return 40; endcase
  endfunction

  // worst-case delay of the request drop after a strobe
  function automatic int rqdly_ns(input int m, input bit wr);
    case (m) 0: return wr ? 40 : 120; 1: return 40; default: return 35; endcase
  endfunction

  function automatic int wsetup_ns(input int m);
    case (m) 0: return 100; 1: return 30; default: return 20; endcase
  endfunction

  function automatic int whold_ns(input int m);
    case (m) 0: return 20; 1: return 15; default: return 10; endcase
  endfunction

  function automatic int ackhold_ns(input int m);
    case (m) 0: return 20; default: return 5; endcase
  endfunction

  function automatic int gap_cyc(input int m, input bit wr, input int clk_ns);
    int g;
    g = imax(ns2cyc(neg_ns(m, wr), clk_ns), ns2cyc(cyc_ns(m) - act_ns(m), clk_ns));
    g = imax(g, ns2cyc(rqdly_ns(m, wr), clk_ns));
    if (wr) g = imax(g, ns2cyc(whold_ns(m), clk_ns));
    return g;
  endfunction
endpackage

// File: rtl/mdma_timing.sv
module mdma_timing
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int TMR_W  = 7
) (
  input  logic [1:0]       mode_i,
  input  logic             wr_i,
  output logic [TMR_W-1:0] act_o,
  output logic [TMR_W-1:0] gap_o,
  output logic [TMR_W-1:0] setup_o,
  output logic [TMR_W-1:0] hold_o
);
  logic [TMR_W-1:0] act_t   [NMODES];
  logic [TMR_W-1:0] gap_r_t [NMODES];
  logic [TMR_W-1:0] gap_w_t [NMODES];
  logic [TMR_W-1:0] su_t    [NMODES];
  logic [TMR_W-1:0] hd_t    [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    assign act_t[m]   = TMR_W'(ns2cyc(act_ns(m), CLK_NS));
    assign gap_r_t[m] = TMR_W'(gap_cyc(m, 1'b0, CLK_NS));
    assign gap_w_t[m] = TMR_W'(gap_cyc(m, 1'b1, CLK_NS));
    assign su_t[m]    = TMR_W'(ns2cyc(wsetup_ns(m), CLK_NS));
    assign hd_t[m]    = TMR_W'(ns2cyc(ackhold_ns(m), CLK_NS));
  end

  logic [1:0] idx;
  assign idx     = (mode_i < 2'(NMODES)) ? mode_i : 2'd0;
  assign act_o   = act_t[idx];
  assign gap_o   = wr_i ? gap_w_t[idx] : gap_r_t[idx];
  assign setup_o = su_t[idx];
  assign hold_o  = hd_t[idx];
endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TMR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dmarq_i,
  input  logic             wr_valid_i,
  input  logic             rd_room_i,
  input  logic [TMR_W-1:0] act_i,
  input  logic [TMR_W-1:0] gap_i,
  input  logic [TMR_W-1:0] setup_i,
  input  logic [TMR_W-1:0] hold_i,
  output logic             dir_q_o,
  output logic [1:0]       mode_q_o,
  output logic             dmack_o,
  output logic             dior_o,
  output logic             diow_o,
  output logic             dd_oe_o,
  output logic             wr_take_o,
  output logic             rd_cap_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] done_count_o
);
  mdma_state_e      state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] left_q, cnt_q;
  logic             dir_q;
  logic [1:0]       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      left_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      mode_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          dir_q   <= dir_i;
          mode_q  <= (mode_i == 2'd3) ? 2'd0 : mode_i;
          left_q  <= count_i;
          cnt_q   <= '0;
          state_q <= (count_i == '0) ? ST_FIN : ST_REQ;
        end
        ST_REQ: if (dmarq_i) state_q <= ST_PREP;
        ST_PREP: begin
          if (dir_q && wr_valid_i) begin
            tmr_q   <= setup_i - 1'b1;
            state_q <= ST_SETUP;
          end else if (!dir_q && rd_room_i) begin
            tmr_q   <= act_i - 1'b1;
            state_q <= ST_STROBE;
          end
        end
        ST_SETUP: begin
          if (tmr_q == '0) begin
            tmr_q   <= act_i - 1'b1;
            state_q <= ST_STROBE;
          end else tmr_q <= tmr_q - 1'b1;
        end
        ST_STROBE: begin
          if (tmr_q == '0) begin
            tmr_q   <= gap_i - 1'b1;
            left_q  <= left_q - 1'b1;
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_GAP;
          end else tmr_q <= tmr_q - 1'b1;
        end
        ST_GAP: begin
          // request sampled only once the worst-case drop delay has elapsed
          if (tmr_q == '0) begin
            if (left_q == '0 || !dmarq_i) begin
              tmr_q   <= hold_i - 1'b1;
              state_q <= ST_HOLD;
            end else state_q <= ST_PREP;
          end else tmr_q <= tmr_q - 1'b1;
        end
        ST_HOLD: begin
          if (tmr_q == '0) state_q <= ST_FIN;
          else tmr_q <= tmr_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dir_q_o      = dir_q;
  assign mode_q_o     = mode_q;
  assign dmack_o      = state_q inside {ST_PREP, ST_SETUP, ST_STROBE, ST_GAP, ST_HOLD};
  assign dior_o       = (state_q == ST_STROBE) && !dir_q;
  assign diow_o       = (state_q == ST_STROBE) && dir_q;
  assign dd_oe_o      = dmack_o && dir_q;
  assign wr_take_o    = (state_q == ST_PREP) && dir_q;
  assign rd_cap_o     = (state_q == ST_STROBE) && !dir_q && (tmr_q == '0);
  assign busy_o       = state_q != ST_IDLE;
  assign done_o       = state_q == ST_FIN;
  assign done_count_o = cnt_q;

  // R3
  ack_before_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dior_o || diow_o) |-> dmack_o);
  // R4
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dior_o && diow_o));
  // R8
  left_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dior_o || diow_o) |-> (left_q != '0));
  // R10
  ack_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dmack_o) |-> $past(!(dior_o || diow_o)));
  // R2
  done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dmack_o);
endmodule

// File: rtl/mdma_rd_stage.sv
module mdma_rd_stage #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  output logic          room_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  input  logic          ready_i
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (cap_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign room_o  = !valid_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R6
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !valid_q);
  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/mdma_host.sv
module mdma_host
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int DW     = 16,
  parameter int CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] done_count_o,
  input  logic             dmarq_i,
  output logic             dmack_o,
  output logic             dior_o,
  output logic             diow_o,
  input  logic [DW-1:0]    dd_i,
  output logic [DW-1:0]    dd_o,
  output logic             dd_oe_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o
);
  localparam int TMR_W = $clog2(ns2cyc(cyc_ns(0), CLK_NS) + 1) + 1;

  logic             dir_q, rd_room, rd_cap, wr_take;
  logic [1:0]       mode_q;
  logic [TMR_W-1:0] act_c, gap_c, setup_c, hold_c;
  logic [DW-1:0]    wr_q;

  mdma_timing #(.CLK_NS(CLK_NS), .TMR_W(TMR_W)) i_timing (
    .mode_i(mode_q), .wr_i(dir_q),
    .act_o(act_c), .gap_o(gap_c), .setup_o(setup_c), .hold_o(hold_c)
  );

  mdma_seq #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .dir_i, .mode_i, .count_i, .dmarq_i,
    .wr_valid_i, .rd_room_i(rd_room),
    .act_i(act_c), .gap_i(gap_c), .setup_i(setup_c), .hold_i(hold_c),
    .dir_q_o(dir_q), .mode_q_o(mode_q),
    .dmack_o, .dior_o, .diow_o, .dd_oe_o,
    .wr_take_o(wr_take), .rd_cap_o(rd_cap),
    .busy_o, .done_o, .done_count_o
  );

  mdma_rd_stage #(.DW(DW)) i_rd (
    .clk_i, .rst_ni, .cap_i(rd_cap), .data_i(dd_i), .room_o(rd_room),
    .data_o(rd_data_o), .valid_o(rd_valid_o), .ready_i(rd_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= '0;
    else if (wr_take && wr_valid_i) wr_q <= wr_data_i;
  end

  assign dd_o       = wr_q;
  assign wr_ready_o = wr_take;

  // R7
  wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diow_o && $past(diow_o)) |-> $stable(dd_o));
  // R7
  wr_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diow_o |-> dd_oe_o);
endmodule

// File: tb/test_mdma_host.sv
`timescale 1ns/1ps
module test_mdma_host;
  localparam int T_NS = 10;
  localparam int DW = 16;
  localparam int CNT_W = 16;
  localparam int ACT_NS [3] = '{240, 80, 80};
  localparam int CYC_NS [3] = '{480, 160, 120};
  localparam int NEGR_NS[3] = '{80, 80, 40};
  localparam int NEGW_NS[3] = '{240, 80, 40};
  localparam int DQR_NS [3] = '{120, 40, 35};
  localparam int DQW_NS [3] = '{40, 40, 35};
  localparam int SU_NS  [3] = '{100, 30, 20};
  localparam int AH_NS  [3] = '{20, 5, 5};

  typedef struct packed {
    logic [1:0] mode; logic dir; logic [7:0] cnt; logic [7:0] drop; logic stall;
  } vec_t;
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 8'd4,  8'd0, 1'b0}, '{2'd1, 1'b0, 8'd6,  8'd0, 1'b0},
    '{2'd2, 1'b0, 8'd8,  8'd0, 1'b0}, '{2'd0, 1'b1, 8'd3,  8'd0, 1'b0},
    '{2'd1, 1'b1, 8'd5,  8'd0, 1'b0}, '{2'd2, 1'b1, 8'd7,  8'd0, 1'b0},
    '{2'd2, 1'b0, 8'd10, 8'd3, 1'b0}, '{2'd1, 1'b1, 8'd10, 8'd4, 1'b0},
    '{2'd2, 1'b0, 8'd6,  8'd0, 1'b1}, '{2'd2, 1'b1, 8'd6,  8'd0, 1'b1},
    '{2'd3, 1'b0, 8'd2,  8'd0, 1'b0}, '{2'd3, 1'b1, 8'd2,  8'd0, 1'b0},
    '{2'd0, 1'b0, 8'd5,  8'd1, 1'b0}, '{2'd1, 1'b1, 8'd3,  8'd3, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, dir_i = 1'b0, rd_ready_i = 1'b0, wr_valid_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic [DW-1:0] dd_i = '0, wr_data_i = '0;
  logic busy_o, done_o, dmarq_i, dmack_o, dior_o, diow_o, dd_oe_o, rd_valid_o, wr_ready_o;
  logic [CNT_W-1:0] done_count_o;
  logic [DW-1:0] dd_o, rd_data_o;

  int errors = 0, checks = 0;
  bit over = 0, mon_clr = 0, dev_req = 0, dropped = 0, cur_dir = 0, stall = 0;
  int cur_cnt = 0, drop_k = 0, exp_act = 1, exp_gap = 1, exp_su = 1, exp_ah = 1;
  int n_fall, s_len, neg_len, stab, ack_len, ack_falls, act_bad, gap_bad, su_bad, ack_bad;
  int word_bad, rx_n, wr_n, cyc_n = 0;
  bit prev_str, prev_wr, prev_ack, taken, strobe;
  logic [DW-1:0] prev_dd;

  always #(T_NS/2) clk_i = ~clk_i;
  assign dmarq_i = dev_req && !dropped;

  mdma_host #(.CLK_NS(T_NS), .DW(DW), .CNT_W(CNT_W)) i_mdma_host (.*);

  function automatic logic [DW-1:0] rd_pat(input int i);
    return DW'(i * 16'h1357 + 16'h0A5C);
  endfunction
  function automatic logic [DW-1:0] wr_pat(input int i);
    return DW'(i * 16'h0F1D + 16'h3C01);
  endfunction
  function automatic int cdiv(input int ns);
    return (ns + T_NS - 1) / T_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) cyc_n++;

  // bus monitor and device model
  always @(negedge clk_i) begin
    if (mon_clr) begin
      n_fall = 0; s_len = 0; neg_len = 0; stab = 0; ack_len = 0; ack_falls = 0;
      act_bad = 0; gap_bad = 0; su_bad = 0; ack_bad = 0; dropped = 0;
      prev_str = 0; prev_wr = 0; prev_ack = 0; prev_dd = dd_o;
    end else begin
      strobe = dior_o || diow_o;
      if (dd_oe_o && dd_o == prev_dd) stab++;
      else stab = dd_oe_o ? 1 : 0;
      if (strobe && !prev_str) begin
        if (n_fall > 0 && neg_len < exp_gap) gap_bad++;
        if (diow_o && (stab - 1) < exp_su) su_bad++;
        s_len = 1;
        if (dior_o) dd_i = rd_pat(n_fall);
      end else if (strobe) s_len++;
      if (!strobe && prev_str) begin
        if (s_len != exp_act) act_bad++;
        if (prev_wr && prev_dd !== wr_pat(n_fall)) word_bad++;
        n_fall++;
        neg_len = 1;
        ack_len = dmack_o ? 1 : 0;
        if (drop_k != 0 && n_fall == drop_k) dropped = 1;
      end else if (!strobe) begin
        neg_len++;
        if (dmack_o) ack_len++;
      end
      if (prev_ack && !dmack_o) begin
        ack_falls++;
        if (n_fall > 0 && ack_len < exp_ah) ack_bad++;
      end
      prev_str = strobe; prev_wr = diow_o; prev_ack = dmack_o; prev_dd = dd_o;
    end
  end

  // stream ends
  always @(negedge clk_i) begin
    if (mon_clr) begin
      rx_n = 0; wr_n = 0; word_bad = 0; taken = 0; wr_valid_i = 0; rd_ready_i = 0;
    end else begin
      rd_ready_i = !stall || (cyc_n % 5 >= 3);
      if (rd_valid_o && rd_ready_i) begin
        if (rd_data_o !== rd_pat(rx_n)) word_bad++;
        rx_n++;
      end
      if (taken) begin wr_valid_i = 0; taken = 0; end
      if (!wr_valid_i && cur_dir && wr_n < cur_cnt && (!stall || cyc_n % 4 == 0)) begin
        wr_valid_i = 1; wr_data_i = wr_pat(wr_n);
      end
      if (wr_valid_i && wr_ready_o) begin wr_n++; taken = 1; end
    end
  end

  task automatic setup_exp(input logic [1:0] mode, input bit dir);
    int m;
    m = (mode == 2'd3) ? 0 : int'(mode);
    exp_act = cdiv(ACT_NS[m]);
    exp_gap = mx(mx(cdiv(dir ? NEGW_NS[m] : NEGR_NS[m]), cdiv(CYC_NS[m] - ACT_NS[m])),
                 cdiv(dir ? DQW_NS[m] : DQR_NS[m]));
    exp_su = cdiv(SU_NS[m]);
    exp_ah = cdiv(AH_NS[m]);
  endtask

  task automatic clear_mon();
    mon_clr = 1;
    @(negedge clk_i);
    mon_clr = 0;
  endtask

  task automatic kick(input bit dir, input logic [1:0] mode, input int cnt);
    start_i = 1; dir_i = dir; mode_i = mode; count_i = CNT_W'(cnt);
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic wait_done(output int got);
    got = -1;
    for (int c = 0; c < 20000; c++) begin
      if (done_o) begin got = int'(done_count_o); break; end
      @(negedge clk_i);
    end
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    int got, exp_n, n;
    setup_exp(v.mode, v.dir);
    cur_dir = v.dir; cur_cnt = int'(v.cnt); drop_k = int'(v.drop); stall = v.stall;
    dev_req = 1;
    clear_mon();
    kick(v.dir, v.mode, int'(v.cnt));
    wait_done(got);
    repeat (40) @(negedge clk_i);
    exp_n = (v.drop != 0 && v.drop < v.cnt) ? int'(v.drop) : int'(v.cnt);
    chk(got == exp_n, $sformatf("vec%0d %s done count", vi, v.drop != 0 ? "R9" : "R8"), got, exp_n);
    n = v.dir ? wr_n : rx_n;
    chk(n == exp_n && word_bad == 0,
        $sformatf("vec%0d %s words", vi, v.stall ? "R11" : (v.dir ? "R7" : "R6")), n, exp_n);
    chk(act_bad == 0, $sformatf("vec%0d %s strobe width", vi, v.mode == 2'd3 ? "R12" : "R4"), act_bad, 0);
    chk(gap_bad == 0, $sformatf("vec%0d R5 negated gap", vi), gap_bad, 0);
    if (v.dir) chk(su_bad == 0, $sformatf("vec%0d R7 data setup", vi), su_bad, 0);
    chk(ack_bad == 0 && ack_falls == 1, $sformatf("vec%0d R10 ack hold", vi), ack_bad, 0);
    dev_req = 0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    int got, bad;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    bad = int'({dmack_o, dior_o, diow_o, dd_oe_o, busy_o, done_o, rd_valid_o, wr_ready_o});
    chk(bad == 0, "R1 reset outputs", bad, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2 zero count
    cur_dir = 0; cur_cnt = 0; drop_k = 0; stall = 0; dev_req = 1;
    clear_mon();
    kick(1'b0, 2'd1, 0);
    wait_done(got);
    chk(got == 0, "R2 zero count done", got, 0);
    repeat (5) @(negedge clk_i);
    chk(ack_falls == 0 && n_fall == 0, "R2 no acknowledge", ack_falls, 0);
    dev_req = 0;

    // R3 wait for request
    setup_exp(2'd2, 1'b0);
    cur_dir = 0; cur_cnt = 3;
    clear_mon();
    kick(1'b0, 2'd2, 3);
    bad = 0;
    for (int c = 0; c < 20; c++) begin
      if (dmack_o || dior_o || diow_o) bad++;
      @(negedge clk_i);
    end
    chk(bad == 0 && busy_o, "R3 ack held off", bad, 0);
    dev_req = 1;
    wait_done(got);
    repeat (20) @(negedge clk_i);
    chk(got == 3 && rx_n == 3 && word_bad == 0, "R3 burst after request", got, 3);
    dev_req = 0;

    over = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(T_NS * 190000);
    if (!over) begin
      errors++; checks++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule